// File: doc/BRIEF.md
# ATA Device Status and Interrupt Register

This block sits on the device side of an ATA-style task file. It keeps the eight-bit status byte, the device control bits and the pending interrupt flag, and it drives the host interrupt line and a soft-reset level toward the device core. The device core moves individual status conditions with per-bit set and clear pulses and raises interrupts with a single pulse.

The host sees status at two addresses. A read at the primary address also acknowledges the interrupt. A read at the alternate address has no side effect. A write at the primary address is a command byte. It is passed to the core only while the device is not busy. A write at the alternate address loads the control bits, which are an interrupt disable and a soft reset.

Top module: `ata_stat_irq`

## Requirements
- R1: After the asynchronous reset, every status bit reads 0 (RDY included), irq_o is 0 and srst_o is 0.
- R2: rdata_o is combinational. While rd_i is high at address 7 (primary) or address 14 (alternate), rdata_o returns the status with bit 7 BUSY, bit 6 RDY, bit 5 DWF, bit 4 DSC, bit 3 DRQ, bit 2 CORR, bit 1 always 0 and bit 0 ERR. In all other cases rdata_o is 0.
- R3: A 1 in bit k of stat_set_i sets status bit k at the next clock edge, and a 1 in bit k of stat_clr_i clears it. When both are 1 for the same bit, the set wins. Bit 1 stays 0 whatever is driven.
- R4: A pulse on irq_set_i makes the interrupt pending. irq_o is 1 exactly when an interrupt is pending and the disable bit is 0. Disabling hides the pending interrupt but does not clear it.
- R5: A read at the primary address clears the pending interrupt at the clock edge on which rd_i is sampled high. A read at the alternate address leaves it pending.
- R6: When irq_set_i and a primary status read fall in the same cycle, the interrupt remains pending.
- R7: A write at the primary address raises cmd_we_o in the same cycle, with cmd_data_o equal to wdata_i, only while BUSY is 0. While BUSY is 1, cmd_we_o stays 0.
- R8: A write at the alternate address is always accepted. Data bit 1 loads the interrupt disable (1 disables) and data bit 2 loads soft reset. The other data bits have no effect.
- R9: While soft reset is 1, srst_o is 1 and BUSY reads 1. The pending interrupt, DRQ and ERR read 0, and set pulses for them and clear pulses for BUSY have no effect.
- R10: After soft reset is written back to 0, BUSY stays 1 until the core pulses stat_clr_i bit 7.
- R11: Setting CORR leaves DRQ and ERR unchanged, so a transfer in progress continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Host register address |
| rd_i | input | 1 | Host read strobe, one cycle per access |
| wr_i | input | 1 | Host write strobe, one cycle per access |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Status read data |
| stat_set_i | input | 8 | Per-bit status set pulses from the core |
| stat_clr_i | input | 8 | Per-bit status clear pulses from the core |
| irq_set_i | input | 1 | Interrupt request pulse from the core |
| irq_o | output | 1 | Host interrupt request |
| srst_o | output | 1 | Soft-reset level to the core |
| cmd_we_o | output | 1 | Accepted command write strobe |
| cmd_data_o | output | 8 | Command byte |

## Verification
The assertions assume the following about the inputs:
- Each host access is a single-cycle strobe that is sampled on exactly one clock edge.
- rd_i and wr_i are never high together.

The stimulus follows this. Every access task raises one strobe just after a rising edge and drops it just after the next one. Core pulses use the same timing.

The scoreboard pairs each issued read with the status value predicted from the requirements. The corner cases targeted are:
- a set and a clear on the same bit in the same cycle;
- an interrupt event that coincides with an acknowledge;
- core pulses issued while soft reset holds the status.

// File: rtl/ata_stat_pkg.sv
`timescale 1ns/1ps
package ata_stat_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned B_BSY  = 7;
  localparam int unsigned B_RDY  = 6;
  localparam int unsigned B_DWF  = 5;
  localparam int unsigned B_DSC  = 4;
  localparam int unsigned B_DRQ  = 3;
  localparam int unsigned B_CORR = 2;
  localparam int unsigned B_ZERO = 1;
  localparam int unsigned B_ERR  = 0;
  localparam int unsigned C_SRST = 2;
  localparam int unsigned C_NIEN = 1;
  typedef struct packed {
    logic srst;
    logic nien;
  } ctrl_t;
endpackage

// File: rtl/ata_stat_bits.sv
`timescale 1ns/1ps
module ata_stat_bits
  import ata_stat_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] frc_set_i,
  input  logic [W-1:0] frc_clr_i,
  output logic [W-1:0] stat_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    if (k == B_ZERO) begin : g_zero
      logic unused_bit;
      assign unused_bit = ^{set_i[k], clr_i[k], frc_set_i[k], frc_clr_i[k]};
      assign stat_o[k]  = 1'b0;
    end else begin : g_reg
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           q <= 1'b0;
        else if (frc_set_i[k]) q <= 1'b1;
        else if (frc_clr_i[k]) q <= 1'b0;
        else if (set_i[k])     q <= 1'b1;
        else if (clr_i[k])     q <= 1'b0;
      end
      assign stat_o[k] = q;
    end
  end
endmodule

// File: rtl/ata_irq_ctrl.sv
`timescale 1ns/1ps
module ata_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  input  logic frc_clr_i,
  input  logic nien_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (frc_clr_i) pend_q <= 1'b0;
    else if (set_i)     pend_q <= 1'b1;  // event beats acknowledge
    else if (ack_i)     pend_q <= 1'b0;
  end
  assign pend_o = pend_q;
  assign irq_o  = pend_q & ~nien_i;
endmodule

// File: rtl/ata_dev_ctrl.sv
`timescale 1ns/1ps
module ata_dev_ctrl
  import ata_stat_pkg::*;
#(
  parameter int unsigned DW = STAT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic          cmd_wr_i,
  input  logic          busy_i,
  input  logic [DW-1:0] wdata_i,
  output ctrl_t         ctrl_o,
  output logic          srst_act_o,
  output logic          cmd_we_o
);
  ctrl_t ctrl_q;
  logic  unused_wd;
  assign unused_wd = ^{wdata_i[DW-1:C_SRST+1], wdata_i[C_NIEN-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctl_we_i) begin
      ctrl_q.srst <= wdata_i[C_SRST];
      ctrl_q.nien <= wdata_i[C_NIEN];
    end
  end

  assign ctrl_o     = ctrl_q;
  // force also on the write edge so BUSY rises with srst
  assign srst_act_o = ctrl_q.srst | (ctl_we_i & wdata_i[C_SRST]);
  assign cmd_we_o   = cmd_wr_i & ~busy_i;
endmodule

// File: rtl/ata_stat_irq.sv
`timescale 1ns/1ps
module ata_stat_irq
  import ata_stat_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DW       = STAT_W,
  parameter int unsigned PRI_ADDR = 7,
  parameter int unsigned ALT_ADDR = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     stat_set_i,
  input  logic [DW-1:0]     stat_clr_i,
  input  logic              irq_set_i,
  output logic              irq_o,
  output logic              srst_o,
  output logic              cmd_we_o,
  output logic [DW-1:0]     cmd_data_o
);
  localparam logic [ADDR_W-1:0] A_PRI = ADDR_W'(PRI_ADDR);
  localparam logic [ADDR_W-1:0] A_ALT = ADDR_W'(ALT_ADDR);

  logic          hit_pri, hit_alt, ack, ctl_we, cmd_wr, srst_act, pend;
  logic [DW-1:0] stat_q, frc_set, frc_clr;
  ctrl_t         ctrl;

  assign hit_pri = (addr_i == A_PRI);
  assign hit_alt = (addr_i == A_ALT);
  assign ack     = rd_i & hit_pri;
  assign ctl_we  = wr_i & hit_alt;
  assign cmd_wr  = wr_i & hit_pri;

  always_comb begin
    frc_set = '0;
    frc_clr = '0;
    frc_set[B_BSY] = srst_act;
    frc_clr[B_DRQ] = srst_act;
    frc_clr[B_ERR] = srst_act;
  end

  ata_stat_bits #(.W(DW)) i_bits (
    .clk_i, .rst_ni,
    .set_i     (stat_set_i),
    .clr_i     (stat_clr_i),
    .frc_set_i (frc_set),
    .frc_clr_i (frc_clr),
    .stat_o    (stat_q)
  );

  ata_dev_ctrl #(.DW(DW)) i_ctrl (
    .clk_i, .rst_ni,
    .ctl_we_i   (ctl_we),
    .cmd_wr_i   (cmd_wr),
    .busy_i     (stat_q[B_BSY]),
    .wdata_i    (wdata_i),
    .ctrl_o     (ctrl),
    .srst_act_o (srst_act),
    .cmd_we_o   (cmd_we_o)
  );

  ata_irq_ctrl i_irq (
    .clk_i, .rst_ni,
    .set_i     (irq_set_i),
    .ack_i     (ack),
    .frc_clr_i (srst_act),
    .nien_i    (ctrl.nien),
    .pend_o    (pend),
    .irq_o     (irq_o)
  );

  assign rdata_o    = (rd_i && (hit_pri || hit_alt)) ? stat_q : '0;
  assign srst_o     = ctrl.srst;
  assign cmd_data_o = wdata_i;
endmodule

// File: rtl/ata_stat_irq_chk.sv
`timescale 1ns/1ps
module ata_stat_irq_chk
  import ata_stat_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DW       = STAT_W,
  parameter int unsigned PRI_ADDR = 7,
  parameter int unsigned ALT_ADDR = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              irq_set_i,
  input logic [DW-1:0]     rdata_o,
  input logic [DW-1:0]     stat_q,
  input logic              pend,
  input logic              nien,
  input logic              irq_o,
  input logic              srst_o,
  input logic              cmd_we_o
);
  a_r2_bit1_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[B_ZERO] == 1'b0);
  a_r4_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend && !nien));
  a_r5_pri_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(PRI_ADDR) && !irq_set_i) |=> !pend);
  a_r5_alt_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(ALT_ADDR) && pend && !srst_o) |=> pend);
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_set_i && !srst_o) |=> (pend || srst_o));
  a_r7_busy_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q[B_BSY] |-> !cmd_we_o);
  a_r9_srst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |-> (stat_q[B_BSY] && !stat_q[B_DRQ] && !stat_q[B_ERR] && !pend));
endmodule

bind ata_stat_irq ata_stat_irq_chk #(
  .ADDR_W(ADDR_W), .DW(DW), .PRI_ADDR(PRI_ADDR), .ALT_ADDR(ALT_ADDR)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i),
  .irq_set_i(irq_set_i), .rdata_o(rdata_o), .stat_q(stat_q), .pend(pend),
  .nien(ctrl.nien), .irq_o(irq_o), .srst_o(srst_o), .cmd_we_o(cmd_we_o)
);

// File: tb/test_ata_stat_irq.sv
`timescale 1ns/1ps
module test_ata_stat_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0, irq_set = 1'b0;
  logic [7:0] wdata = '0, stat_set = '0, stat_clr = '0;
  logic [7:0] rdata, cmd_data;
  logic       irq, srst, cmd_we;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct { logic [7:0] e; string r; } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  ata_stat_irq i_ata_stat_irq (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .stat_set_i(stat_set),
    .stat_clr_i(stat_clr), .irq_set_i(irq_set), .irq_o(irq), .srst_o(srst),
    .cmd_we_o(cmd_we), .cmd_data_o(cmd_data)
  );

  // monitor: compare each read against the scoreboard
  always @(negedge clk) begin
    if (rd && !done) begin
      item_t it;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL %s: unexpected read act=%h exp=none", "R2", rdata);
      end else begin
        it = exp_q.pop_front();
        if (rdata !== it.e) begin
          bad++;
          $display("FAIL %s: rdata act=%h exp=%h", it.r, rdata, it.e);
        end
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string r);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", r, act, e);
    end
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [7:0] e, input string r);
    @(posedge clk); #1;
    addr = a; rd = 1'b1;
    exp_q.push_back('{e: e, r: r});
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d,
                        output logic we, output logic [7:0] cd);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    we = cmd_we; cd = cmd_data;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic core(input logic [7:0] s, input logic [7:0] c, input logic ir);
    @(posedge clk); #1;
    stat_set = s; stat_clr = c; irq_set = ir;
    @(posedge clk); #1;
    stat_set = '0; stat_clr = '0; irq_set = 1'b0;
  endtask

  task automatic look(output logic i, output logic s);
    @(negedge clk);
    i = irq; s = srst;
  endtask

  task automatic finish_run;
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R2: pending reads act=%0d exp=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    done = 1;
    $display("FAIL watchdog: act=timeout exp=finish");
    finish_run();
  end

  initial begin
    logic i, s, we;
    logic [7:0] cd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    look(i, s);
    chk({7'd0, i}, 8'd0, "R1 irq");
    chk({7'd0, s}, 8'd0, "R1 srst");
    rd_exp(4'd14, 8'h00, "R1");

    core(8'h52, 8'h00, 1'b0);                // RDY, DSC, bit1 attempt
    rd_exp(4'd7, 8'h50, "R3");
    core(8'h01, 8'h01, 1'b0);                // set wins
    rd_exp(4'd7, 8'h51, "R3");
    core(8'h00, 8'h01, 1'b0);
    rd_exp(4'd14, 8'h50, "R2");
    rd_exp(4'd3, 8'h00, "R2");

    core(8'h00, 8'h00, 1'b1);
    look(i, s); chk({7'd0, i}, 8'd1, "R4 raise");
    rd_exp(4'd14, 8'h50, "R5");
    look(i, s); chk({7'd0, i}, 8'd1, "R5 alt keeps");
    wr_reg(4'd14, 8'h02, we, cd);
    look(i, s); chk({7'd0, i}, 8'd0, "R4 masked");
    wr_reg(4'd14, 8'h00, we, cd);
    look(i, s); chk({7'd0, i}, 8'd1, "R4 unmask pending");
    rd_exp(4'd7, 8'h50, "R5");
    look(i, s); chk({7'd0, i}, 8'd0, "R5 pri clears");

    @(posedge clk); #1;
    irq_set = 1'b1; addr = 4'd7; rd = 1'b1;
    exp_q.push_back('{e: 8'h50, r: "R6"});
    @(posedge clk); #1;
    irq_set = 1'b0; rd = 1'b0;
    look(i, s); chk({7'd0, i}, 8'd1, "R6 kept");
    rd_exp(4'd7, 8'h50, "R5");

    wr_reg(4'd7, 8'hEC, we, cd);
    chk({7'd0, we}, 8'd1, "R7 accept");
    chk(cd, 8'hEC, "R7 data");
    core(8'h80, 8'h00, 1'b0);
    wr_reg(4'd7, 8'h20, we, cd);
    chk({7'd0, we}, 8'd0, "R7 busy lock");
    core(8'h00, 8'h80, 1'b0);

    core(8'h08, 8'h00, 1'b0);
    core(8'h04, 8'h00, 1'b0);
    rd_exp(4'd7, 8'h5C, "R11");
    core(8'h01, 8'h00, 1'b1);
    rd_exp(4'd14, 8'h5D, "R3");

    wr_reg(4'd14, 8'hF4, we, cd);
    look(i, s);
    chk({7'd0, s}, 8'd1, "R9 srst");
    chk({7'd0, i}, 8'd0, "R9 irq cleared");
    rd_exp(4'd14, 8'hD4, "R9");
    core(8'h09, 8'h80, 1'b1);
    rd_exp(4'd14, 8'hD4, "R9");
    look(i, s); chk({7'd0, i}, 8'd0, "R9 irq held");

    wr_reg(4'd14, 8'h08, we, cd);
    look(i, s); chk({7'd0, s}, 8'd0, "R10 srst released");
    rd_exp(4'd14, 8'hD4, "R10");
    wr_reg(4'd7, 8'h11, we, cd);
    chk({7'd0, we}, 8'd0, "R7 busy after srst");
    core(8'h00, 8'h80, 1'b0);
    rd_exp(4'd14, 8'h54, "R10");

    wr_reg(4'd14, 8'hFA, we, cd);
    core(8'h00, 8'h00, 1'b1);
    look(i, s);
    chk({7'd0, i}, 8'd0, "R8 disable bit");
    chk({7'd0, s}, 8'd0, "R8 srst bit clear");
    wr_reg(4'd14, 8'h09, we, cd);
    look(i, s);
    chk({7'd0, i}, 8'd1, "R8 other bits ignored");
    chk({7'd0, s}, 8'd0, "R8 no srst");
    rd_exp(4'd7, 8'h54, "R5");

    repeat (2) @(posedge clk);
    done = 1;
    finish_run();
  end
endmodule